// File: doc/BRIEF.md
# Bus-Master Data Fault Injector

This block sits on the link between one AHB master and the shared interconnect. Every address-phase and control signal passes straight through it, and the ready and response signals pass back. The block watches the transfers its master completes. When an entry of its small fault list fires, it flips bits of the data bus during the matching data phases. Each master gets its own copy, and each copy decides on its own when to inject. No central controller is involved.

A fault entry is loaded through a one-cycle configuration write. It names a trigger kind, a trigger value, an XOR mask and a duration in transfers. A count trigger fires on the Nth completed transfer since reset, whether that transfer is a single or part of a burst. A burst trigger waits for the Nth burst and then corrupts the sequential beats of that burst. In both kinds an entry retires once its duration is spent. Corruption follows the AHB pipeline: the decision is made in the address phase and is applied one stage later, in that transfer's data phase. Write data is corrupted on its way to the bus and read data on its way to the master. When no fault is due the block adds no latency at all.

Top module: `ahb_fault_injector`

## Requirements
- R1: Address, transfer type, direction, size and burst pass from master to bus combinationally; ready and response pass from bus to master combinationally; outside a faulted data phase both data buses pass unchanged.
- R2: A transfer is accepted when the transfer type is NONSEQ (2'b10) or SEQ (2'b11) while ready is high. IDLE (2'b00), BUSY (2'b01) and stalled cycles are never counted and never corrupted.
- R3: An entry in count mode (mode bit 0) fires on the accepted transfer whose 1-based count since reset equals its trigger value. It corrupts that transfer and the following duration-1 accepted transfers, then retires.
- R4: The data phase of a faulted transfer carries data XOR mask. Write data toward the bus is corrupted when the captured direction bit is 1 (write); read data toward the master is corrupted when it is 0 (read). The other data direction stays untouched.
- R5: Bursts are counted on accepted NONSEQ transfers with a burst code other than 3'b000. An entry in burst mode (mode bit 1) arms on the NONSEQ of the burst whose ordinal equals its trigger. It then corrupts the following accepted SEQ beats, up to its duration, and leaves the NONSEQ beat clean.
- R6: A burst-mode entry retires at the next accepted NONSEQ even when its duration is not spent. BUSY beats inside the burst neither get corrupted nor use up duration.
- R7: Entries act independently. When several entries hit the same transfer, the applied mask is the XOR of their masks.
- R8: An entry with duration 0 retires at its trigger without corrupting anything. A retired entry never fires again until it is reloaded.
- R9: While ready is low the data-phase corruption is held unchanged, so an extended data phase carries the same mask throughout.
- R10: A configuration write to an index replaces that entry's settings and clears its progress; writing it with enable 0 stops a fault that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| m_haddr | input | ADDR_W | Address from master |
| m_htrans | input | 2 | Transfer type from master |
| m_hwrite | input | 1 | Direction from master (1 = write) |
| m_hsize | input | 3 | Transfer size from master |
| m_hburst | input | 3 | Burst code from master |
| m_hwdata | input | DATA_W | Write data from master |
| m_hrdata | output | DATA_W | Read data to master, possibly corrupted |
| m_hready | output | 1 | Ready to master |
| m_hresp | output | 1 | Response to master |
| b_haddr | output | ADDR_W | Address to bus |
| b_htrans | output | 2 | Transfer type to bus |
| b_hwrite | output | 1 | Direction to bus |
| b_hsize | output | 3 | Size to bus |
| b_hburst | output | 3 | Burst code to bus |
| b_hwdata | output | DATA_W | Write data to bus, possibly corrupted |
| b_hrdata | input | DATA_W | Read data from bus |
| b_hready | input | 1 | Ready from bus |
| b_hresp | input | 1 | Response from bus |
| cfg_we | input | 1 | Load one fault entry this cycle |
| cfg_idx | input | IDX_W | Entry index to load |
| cfg_en | input | 1 | Entry enable |
| cfg_mode | input | 1 | 0 = count trigger, 1 = burst trigger |
| cfg_trig | input | CNT_W | Transfer count or burst ordinal |
| cfg_mask | input | DATA_W | XOR mask |
| cfg_dur | input | DUR_W | Duration in transfers |

## Verification
Pass-through results are due in the same cycle as their inputs. A fault decided on the address phase accepted at edge k appears on the data buses right after edge k. It stays there until the edge at which ready is next seen high. The bench's reference model updates its expected data-phase mask at each rising edge, from the inputs it held during the cycle before. All outputs are sampled 1 ns after that edge, once the design's data-phase register and the model have settled. Per-scenario counts of corrupted data phases, taken only in cycles with ready high, give a second check on fault placement that does not use the model.

// File: rtl/fi_pkg.sv
package fi_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   typedef enum logic {
      MODE_COUNT = 1'b0,
      MODE_BURST = 1'b1
   } trig_mode_e;

   localparam logic [2:0] BURST_SINGLE = 3'b000;

endpackage

// File: rtl/fi_monitor.sv
// Bus monitor: decodes accepted transfers and keeps the transfer and burst tallies.
module fi_monitor #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       htrans,
   input  logic [2:0]       hburst,
   input  logic             hready,
   output logic             acc,
   output logic             acc_nonseq,
   output logic             acc_seq,
   output logic             burst_start,
   output logic [CNT_W-1:0] xfer_next,
   output logic [CNT_W-1:0] burst_next
);
   import fi_pkg::*;

   logic [CNT_W-1:0] xfer_cnt;
   logic [CNT_W-1:0] burst_cnt;

   always_comb begin
      acc         = hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
      acc_nonseq  = hready && (htrans == TR_NONSEQ);
      acc_seq     = hready && (htrans == TR_SEQ);
      burst_start = acc_nonseq && (hburst != BURST_SINGLE);
      xfer_next   = xfer_cnt + CNT_W'(1);
      burst_next  = burst_cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_cnt  <= '0;
         burst_cnt <= '0;
      end else begin
         if (acc)         xfer_cnt  <= xfer_next;
         if (burst_start) burst_cnt <= burst_next;
      end
   end

endmodule

// File: rtl/fi_entry.sv
// One fault-list slot: holds its settings, checks its trigger, counts its duration.
module fi_entry #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int DUR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_en,
   input  logic              ld_mode,
   input  logic [CNT_W-1:0]  ld_trig,
   input  logic [DATA_W-1:0] ld_mask,
   input  logic [DUR_W-1:0]  ld_dur,
   input  logic              acc,
   input  logic              acc_nonseq,
   input  logic              acc_seq,
   input  logic              burst_start,
   input  logic [CNT_W-1:0]  xfer_next,
   input  logic [CNT_W-1:0]  burst_next,
   output logic              hit,
   output logic [DATA_W-1:0] mask
);
   import fi_pkg::*;

   logic             armed;
   logic             running;
   trig_mode_e       mode;
   logic [CNT_W-1:0] trig;
   logic [DUR_W-1:0] dur;
   logic [DUR_W-1:0] left;

   logic cnt_match;
   logic brst_match;
   logic dur_zero;
   logic last_beat;

   always_comb begin
      cnt_match  = (mode == MODE_COUNT) && (xfer_next == trig);
      brst_match = (mode == MODE_BURST) && burst_start && (burst_next == trig);
      dur_zero   = (dur == '0);
      last_beat  = (left == DUR_W'(1));
      hit        = 1'b0;
      if (armed && !load && acc) begin
         if (mode == MODE_COUNT) hit = running || (cnt_match && !dur_zero);
         else                    hit = running && acc_seq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         running <= 1'b0;
         mode    <= MODE_COUNT;
         trig    <= '0;
         mask    <= '0;
         dur     <= '0;
         left    <= '0;
      end else if (load) begin
         armed   <= ld_en;
         running <= 1'b0;
         mode    <= trig_mode_e'(ld_mode);
         trig    <= ld_trig;
         mask    <= ld_mask;
         dur     <= ld_dur;
         left    <= '0;
      end else if (armed && acc) begin
         if (mode == MODE_COUNT) begin
            if (running) begin
               left <= left - DUR_W'(1);
               if (last_beat) begin
                  running <= 1'b0;
                  armed   <= 1'b0;
               end
            end else if (cnt_match) begin
               if (dur <= DUR_W'(1)) begin
                  armed <= 1'b0;
               end else begin
                  running <= 1'b1;
                  left    <= dur - DUR_W'(1);
               end
            end
         end else begin
            if (acc_nonseq) begin
               if (running) begin
                  running <= 1'b0;
                  armed   <= 1'b0;
               end else if (brst_match) begin
                  if (dur_zero) begin
                     armed <= 1'b0;
                  end else begin
                     running <= 1'b1;
                     left    <= dur;
                  end
               end
            end else if (acc_seq && running) begin
               left <= left - DUR_W'(1);
               if (last_beat) begin
                  running <= 1'b0;
                  armed   <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/fi_datapath.sv
// Carries the address-phase decision into the data phase and applies the XOR.
module fi_datapath #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hready,
   input  logic              acc,
   input  logic              hwrite,
   input  logic [DATA_W-1:0] addr_mask,
   input  logic [DATA_W-1:0] m_hwdata,
   input  logic [DATA_W-1:0] b_hrdata,
   output logic [DATA_W-1:0] b_hwdata,
   output logic [DATA_W-1:0] m_hrdata
);
   logic [DATA_W-1:0] dp_mask;
   logic              dp_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_mask  <= '0;
         dp_write <= 1'b0;
      end else if (hready) begin
         dp_mask  <= acc ? addr_mask : '0;
         dp_write <= hwrite;
      end
   end

   always_comb begin
      b_hwdata = m_hwdata ^ (dp_write ? dp_mask : '0);
      m_hrdata = b_hrdata ^ (dp_write ? '0 : dp_mask);
   end

endmodule

// File: rtl/ahb_fault_injector.sv
module ahb_fault_injector #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int N_ENTRIES = 4,
   parameter int CNT_W     = 32,
   parameter int DUR_W     = 8,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] m_haddr,
   input  logic [1:0]        m_htrans,
   input  logic              m_hwrite,
   input  logic [2:0]        m_hsize,
   input  logic [2:0]        m_hburst,
   input  logic [DATA_W-1:0] m_hwdata,
   output logic [DATA_W-1:0] m_hrdata,
   output logic              m_hready,
   output logic              m_hresp,
   output logic [ADDR_W-1:0] b_haddr,
   output logic [1:0]        b_htrans,
   output logic              b_hwrite,
   output logic [2:0]        b_hsize,
   output logic [2:0]        b_hburst,
   output logic [DATA_W-1:0] b_hwdata,
   input  logic [DATA_W-1:0] b_hrdata,
   input  logic              b_hready,
   input  logic              b_hresp,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   input  logic [CNT_W-1:0]  cfg_trig,
   input  logic [DATA_W-1:0] cfg_mask,
   input  logic [DUR_W-1:0]  cfg_dur
);

   generate
      if (N_ENTRIES < 2 || N_ENTRIES > 64) begin : g_bad_entries
         $error("N_ENTRIES must lie in 2..64");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("DATA_W must be a multiple of 8");
      end
      if (CNT_W < 4 || CNT_W > 64) begin : g_bad_cnt
         $error("CNT_W must lie in 4..64");
      end
      if (DUR_W < 1 || DUR_W > 16) begin : g_bad_dur
         $error("DUR_W must lie in 1..16");
      end
   endgenerate

   // combinational pass-through of the address phase and the response path
   always_comb begin
      b_haddr  = m_haddr;
      b_htrans = m_htrans;
      b_hwrite = m_hwrite;
      b_hsize  = m_hsize;
      b_hburst = m_hburst;
      m_hready = b_hready;
      m_hresp  = b_hresp;
   end

   logic             acc;
   logic             acc_nonseq;
   logic             acc_seq;
   logic             burst_start;
   logic [CNT_W-1:0] xfer_next;
   logic [CNT_W-1:0] burst_next;

   fi_monitor #(.CNT_W(CNT_W)) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .htrans      (m_htrans),
      .hburst      (m_hburst),
      .hready      (b_hready),
      .acc         (acc),
      .acc_nonseq  (acc_nonseq),
      .acc_seq     (acc_seq),
      .burst_start (burst_start),
      .xfer_next   (xfer_next),
      .burst_next  (burst_next)
   );

   logic [N_ENTRIES-1:0] hit_v;
   logic [DATA_W-1:0]    mask_v [N_ENTRIES];

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
      logic load_g;
      assign load_g = cfg_we && (cfg_idx == IDX_W'(g));

      fi_entry #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DUR_W(DUR_W)) u_ent (
         .clk         (clk),
         .rst_n       (rst_n),
         .load        (load_g),
         .ld_en       (cfg_en),
         .ld_mode     (cfg_mode),
         .ld_trig     (cfg_trig),
         .ld_mask     (cfg_mask),
         .ld_dur      (cfg_dur),
         .acc         (acc),
         .acc_nonseq  (acc_nonseq),
         .acc_seq     (acc_seq),
         .burst_start (burst_start),
         .xfer_next   (xfer_next),
         .burst_next  (burst_next),
         .hit         (hit_v[g]),
         .mask        (mask_v[g])
      );
   end

   logic [DATA_W-1:0] addr_mask;

   always_comb begin
      addr_mask = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (hit_v[i]) addr_mask = addr_mask ^ mask_v[i];
      end
   end

   fi_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .hready    (b_hready),
      .acc       (acc),
      .hwrite    (m_hwrite),
      .addr_mask (addr_mask),
      .m_hwdata  (m_hwdata),
      .b_hrdata  (b_hrdata),
      .b_hwdata  (b_hwdata),
      .m_hrdata  (m_hrdata)
   );

endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        m_htrans,
   input logic              m_hwrite,
   input logic              b_hready,
   input logic [DATA_W-1:0] m_hwdata,
   input logic [DATA_W-1:0] b_hwdata,
   input logic [DATA_W-1:0] m_hrdata,
   input logic [DATA_W-1:0] b_hrdata
);

   // R2: a data phase that follows an accepted IDLE or BUSY is never corrupted
   p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_hready && !m_htrans[1]) |-> (b_hwdata == m_hwdata && m_hrdata == b_hrdata));

   // R4: a read transfer leaves write data untouched
   p_write_side_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_hready && m_htrans[1] && !m_hwrite) |-> (b_hwdata == m_hwdata));

   // R4: a write transfer leaves read data untouched
   p_read_side_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_hready && m_htrans[1] && m_hwrite) |-> (m_hrdata == b_hrdata));

   // R9: corruption is held while the data phase is stretched
   p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!b_hready) |-> (((b_hwdata ^ m_hwdata) == $past(b_hwdata ^ m_hwdata)) &&
                            ((m_hrdata ^ b_hrdata) == $past(m_hrdata ^ b_hrdata))));

endmodule

bind ahb_fault_injector fi_checker #(.DATA_W(DATA_W)) u_fi_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .m_htrans (m_htrans),
   .m_hwrite (m_hwrite),
   .b_hready (b_hready),
   .m_hwdata (m_hwdata),
   .b_hwdata (b_hwdata),
   .m_hrdata (m_hrdata),
   .b_hrdata (b_hrdata)
);

// File: tb/test_ahb_fault_injector.sv
`timescale 1ns/1ps
module test_ahb_fault_injector;
   localparam int NE = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic [31:0] m_haddr;
   logic [1:0]  m_htrans;
   logic        m_hwrite;
   logic [2:0]  m_hsize;
   logic [2:0]  m_hburst;
   logic [31:0] m_hwdata;
   logic [31:0] m_hrdata;
   logic        m_hready;
   logic        m_hresp;
   logic [31:0] b_haddr;
   logic [1:0]  b_htrans;
   logic        b_hwrite;
   logic [2:0]  b_hsize;
   logic [2:0]  b_hburst;
   logic [31:0] b_hwdata;
   logic [31:0] b_hrdata;
   logic        b_hready;
   logic        b_hresp;
   logic        cfg_we;
   logic [1:0]  cfg_idx;
   logic        cfg_en;
   logic        cfg_mode;
   logic [31:0] cfg_trig;
   logic [31:0] cfg_mask;
   logic [7:0]  cfg_dur;

   ahb_fault_injector i_ahb_fault_injector (.*);

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "R1";
   int    corrupt_seen = 0;
   int    wdiff_seen   = 0;
   logic [31:0] last_diff = '0;
   int unsigned n_xfers = 0;
   int unsigned n_bursts = 0;
   bit    wait_on = 1'b0;
   int    cyc = 0;
   logic [31:0] lf = 32'h1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // slave side and data stimulus, driven away from the sampling edge
   always @(negedge clk) begin
      lf       <= {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      m_hwdata <= lf;
      b_hrdata <= ~lf ^ 32'h5a5a_0f0f;
      b_hready <= !(wait_on && (cyc % 3 == 1));
      b_hresp  <= lf[3];
      cyc      <= cyc + 1;
   end

   // behavioural reference model
   logic        md_en   [NE];
   logic        md_mode [NE];
   logic [31:0] md_trig [NE];
   logic [31:0] md_msk  [NE];
   int          md_dur  [NE];
   logic        md_busy [NE];
   int          md_rem  [NE];
   logic [31:0] xcnt, bcnt, xn, bn, accm, e_mask;
   logic        e_wr, acc, nseq, sq, bst;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NE; i++) begin
            md_en[i] = 0; md_mode[i] = 0; md_trig[i] = 0; md_msk[i] = 0;
            md_dur[i] = 0; md_busy[i] = 0; md_rem[i] = 0;
         end
         xcnt = 0; bcnt = 0; e_mask = 0; e_wr = 0;
      end else begin
         acc  = b_hready && m_htrans[1];
         nseq = acc && (m_htrans == 2'b10);
         sq   = acc && (m_htrans == 2'b11);
         bst  = nseq && (m_hburst != 3'b000);
         xn   = xcnt + 1;
         bn   = bcnt + 1;
         accm = 0;
         for (int i = 0; i < NE; i++) begin
            if (cfg_we && cfg_idx == 2'(i)) begin
               md_en[i] = cfg_en; md_mode[i] = cfg_mode; md_trig[i] = cfg_trig;
               md_msk[i] = cfg_mask; md_dur[i] = int'(cfg_dur); md_busy[i] = 0; md_rem[i] = 0;
            end else if (md_en[i] && acc) begin
               if (!md_mode[i]) begin
                  if (md_busy[i]) begin
                     accm ^= md_msk[i];
                     md_rem[i]--;
                     if (md_rem[i] == 0) begin md_busy[i] = 0; md_en[i] = 0; end
                  end else if (xn == md_trig[i]) begin
                     if (md_dur[i] > 0) accm ^= md_msk[i];
                     if (md_dur[i] <= 1) md_en[i] = 0;
                     else begin md_busy[i] = 1; md_rem[i] = md_dur[i] - 1; end
                  end
               end else begin
                  if (nseq) begin
                     if (md_busy[i]) begin md_busy[i] = 0; md_en[i] = 0; end
                     else if (bst && bn == md_trig[i]) begin
                        if (md_dur[i] == 0) md_en[i] = 0;
                        else begin md_busy[i] = 1; md_rem[i] = md_dur[i]; end
                     end
                  end else if (sq && md_busy[i]) begin
                     accm ^= md_msk[i];
                     md_rem[i]--;
                     if (md_rem[i] == 0) begin md_busy[i] = 0; md_en[i] = 0; end
                  end
               end
            end
         end
         if (acc) xcnt = xn;
         if (bst) bcnt = bn;
         if (b_hready) begin
            e_mask = acc ? accm : 32'h0;
            e_wr   = m_hwrite;
         end
      end
   end

   // per-cycle comparison, 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk(b_hwdata == (m_hwdata ^ (e_wr ? e_mask : 32'h0)), {tag, " R4 wdata"},
             b_hwdata, m_hwdata ^ (e_wr ? e_mask : 32'h0));
         chk(m_hrdata == (b_hrdata ^ (e_wr ? 32'h0 : e_mask)), {tag, " R4 rdata"},
             m_hrdata, b_hrdata ^ (e_wr ? 32'h0 : e_mask));
         chk(b_haddr == m_haddr && b_htrans == m_htrans && b_hwrite == m_hwrite &&
             b_hsize == m_hsize && b_hburst == m_hburst, "R1 address pass", b_haddr, m_haddr);
         chk(m_hready == b_hready && m_hresp == b_hresp, "R1 response pass",
             {30'h0, m_hready, m_hresp}, {30'h0, b_hready, b_hresp});
         if (b_hready && ((b_hwdata ^ m_hwdata) | (m_hrdata ^ b_hrdata)) != 0) begin
            corrupt_seen++;
            last_diff = (b_hwdata ^ m_hwdata) | (m_hrdata ^ b_hrdata);
            if (b_hwdata != m_hwdata) wdiff_seen++;
         end
      end
   end

   task automatic issue(input logic [1:0] tr, input logic [2:0] bu, input logic wr);
      @(negedge clk);
      m_htrans = tr;
      m_hburst = bu;
      m_hwrite = wr;
      m_hsize  = 3'b010;
      m_haddr  = m_haddr + 32'h4;
      if (tr[1]) n_xfers++;
      if (tr == 2'b10 && bu != 3'b000) n_bursts++;
      do @(posedge clk); while (!b_hready);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) issue(2'b00, 3'b000, 1'b0);
   endtask

   task automatic cfg(input int idx, input bit en, input bit md, input int unsigned trg,
                      input logic [31:0] msk, input int dur);
      @(negedge clk);
      cfg_we = 1; cfg_idx = 2'(idx); cfg_en = en; cfg_mode = md;
      cfg_trig = trg; cfg_mask = msk; cfg_dur = 8'(dur);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic burst4(input logic wr);
      issue(2'b10, 3'b011, wr);
      for (int k = 0; k < 3; k++) issue(2'b11, 3'b011, wr);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      rst_n = 0; m_haddr = 0; m_htrans = 0; m_hwrite = 0; m_hsize = 0; m_hburst = 0;
      cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_mode = 0; cfg_trig = 0; cfg_mask = 0; cfg_dur = 0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1;
      idle(3);
      @(negedge clk);
      chk(b_hwdata == m_hwdata, "R1 reset wdata clean", b_hwdata, m_hwdata);
      chk(m_hrdata == b_hrdata, "R1 reset rdata clean", m_hrdata, b_hrdata);

      // R2 R3: three single-transfer count triggers among IDLE and BUSY cycles
      tag = "R2 R3";
      cfg(0, 1, 0, n_xfers + 5,  32'h0000_00ff, 1);
      cfg(1, 1, 0, n_xfers + 8,  32'h0f00_0000, 1);
      cfg(2, 1, 0, n_xfers + 12, 32'h8000_0001, 1);
      base = corrupt_seen;
      for (int k = 0; k < 15; k++) begin
         issue(2'b10, 3'b000, k[0]);
         if (k % 3 == 0) issue(2'b01, 3'b000, 1'b0);
         if (k % 4 == 1) idle(1);
      end
      idle(2);
      chk(corrupt_seen - base == 3, "R3 count triggers fire once each", corrupt_seen - base, 3);

      // R9: duration three with wait states
      tag = "R9 R3";
      wait_on = 1;
      cfg(3, 1, 0, n_xfers + 3, 32'h00ff_ff00, 3);
      base = corrupt_seen;
      for (int k = 0; k < 6; k++) issue(2'b10, 3'b000, k < 3);
      idle(2);
      wait_on = 0;
      chk(corrupt_seen - base == 3, "R9 R3 three-transfer fault under waits", corrupt_seen - base, 3);

      // R5 R6: second burst, SEQ beats only, BUSY inside the burst
      tag = "R5 R6";
      cfg(0, 1, 1, n_bursts + 2, 32'h1234_5678, 3);
      base = corrupt_seen;
      burst4(1'b1);
      issue(2'b10, 3'b000, 1'b1);
      issue(2'b10, 3'b011, 1'b1);
      issue(2'b11, 3'b011, 1'b1);
      issue(2'b01, 3'b011, 1'b1);
      issue(2'b11, 3'b011, 1'b1);
      issue(2'b11, 3'b011, 1'b1);
      burst4(1'b1);
      idle(2);
      chk(corrupt_seen - base == 3, "R5 beats two to four of the second burst", corrupt_seen - base, 3);

      // R6: duration longer than the burst retires at the next NONSEQ
      tag = "R6";
      cfg(1, 1, 1, n_bursts + 1, 32'h0000_f00f, 5);
      base = corrupt_seen;
      burst4(1'b0);
      burst4(1'b0);
      idle(2);
      chk(corrupt_seen - base == 3, "R6 early retirement at next NONSEQ", corrupt_seen - base, 3);

      // R7: two entries on the same transfer
      tag = "R7";
      cfg(0, 1, 0, n_xfers + 2, 32'h0000_00f0, 1);
      cfg(1, 1, 0, n_xfers + 2, 32'h0000_0ff0, 1);
      base = corrupt_seen;
      for (int k = 0; k < 3; k++) issue(2'b10, 3'b000, 1'b1);
      idle(2);
      chk(corrupt_seen - base == 1, "R7 one corrupted phase", corrupt_seen - base, 1);
      chk(last_diff == 32'h0000_0f00, "R7 masks combine by XOR", last_diff, 32'h0000_0f00);

      // R8: zero duration never corrupts, spent entries stay silent
      tag = "R8";
      cfg(2, 1, 0, n_xfers + 1, 32'hffff_ffff, 0);
      base = corrupt_seen;
      for (int k = 0; k < 5; k++) issue(2'b10, 3'b000, k[0]);
      burst4(1'b1);
      idle(2);
      chk(corrupt_seen - base == 0, "R8 zero duration and retired entries", corrupt_seen - base, 0);

      // R10: disabling an entry mid-duration stops the fault
      tag = "R10";
      cfg(3, 1, 0, n_xfers + 2, 32'h0f0f_0f0f, 4);
      base = corrupt_seen;
      for (int k = 0; k < 3; k++) issue(2'b10, 3'b000, 1'b1);
      idle(1);
      cfg(3, 0, 0, 0, 32'h0f0f_0f0f, 4);
      for (int k = 0; k < 3; k++) issue(2'b10, 3'b000, 1'b1);
      idle(2);
      chk(corrupt_seen - base == 2, "R10 reload stops running fault", corrupt_seen - base, 2);

      // R4: read-only fault touches read data only
      tag = "R4";
      cfg(0, 1, 0, n_xfers + 1, 32'hc3c3_0000, 2);
      base = wdiff_seen;
      begin
         int b2;
         b2 = corrupt_seen;
         issue(2'b10, 3'b000, 1'b0);
         issue(2'b10, 3'b000, 1'b0);
         idle(2);
         chk(corrupt_seen - b2 == 2, "R4 two read phases corrupted", corrupt_seen - b2, 2);
         chk(last_diff == 32'hc3c3_0000, "R4 read mask value", last_diff, 32'hc3c3_0000);
      end
      chk(wdiff_seen == base, "R4 write data untouched on reads", wdiff_seen, base);

      finish_run();
   end

endmodule